// File: doc/BRIEF.md
# USB Device Suspend and Resume Controller

This block watches the decoded line state of a full-speed USB device and runs its low-power sequence. If the bus sits in the idle J state long enough, the block raises a suspend flag and, when enabled, an interrupt. Firmware then moves the device into sleep with a guarded two-step write. It must first set a lock bit. It then writes the commit bit to 1 and back to 0. If the host drives the bus again before the second write, the flag drops and the sequence is cancelled.

While asleep, the block drops its clock-enable output and raises a suspend pin. A power-option bit decides whether the sleep is shown as an external power cut (bus-powered) or as tri-stated shared pins (self-powered). Every register write is refused during sleep. Either of two events wakes the device: a K state held long enough by the host, or a local wake request. On wake, clocks return and a resume flag is set for firmware. Reads are marked not ready until a recovery window of several read-recovery periods has passed.

The register interface has one select bit and a 5-bit data path. Reads are combinational from the selected register.

Top module: `usb_susp_ctl`

## Requirements
- R1: Line state encoding is 2'b01 J, 2'b10 K, 2'b00 SE0 and 2'b11 SE1. The suspend flag (status bit 0, reg_sel=1) becomes 1 at the clock edge that samples the IDLE_CYCLES-th consecutive J. It is still 0 after IDLE_CYCLES-1 such samples. While awake, any non-J sample clears the flag and restarts the count.
- R2: When the detection-disable bit (control bit 1, reg_sel=0) is 1, no run of J sets the suspend flag.
- R3: The device commits to sleep only under these conditions: the lock bit (control bit 0) is 1 and the flag is set. Firmware writes status bit 0 as 1, then writes it as 0 while the line is still J. From the next cycle on, susp_o is 1, clk_en is 0 and status bit 2 reads 1.
- R4: While the lock bit is 0, writes to status bit 0 have no effect.
- R5: While asleep, register writes are ignored, and the control register reads back unchanged.
- R6: irq equals (suspend flag AND control bit 3) OR (resume flag AND control bit 4). The suspend flag stays 1 during the whole sleep.
- R7: A non-J sample between the two commit writes clears the flag and cancels the armed write. The later write of 0 then leaves the device awake.
- R8: While asleep, pwr_off follows the power-option bit (control bit 2) and pad_hiz follows its inverse. Both are 0 while awake.
- R9: While asleep, RESUME_CYCLES consecutive K samples wake the device. A shorter K run does not.
- R10: wake_req wakes the device. On any wake, the suspend flag clears and the resume flag (status bit 1) is set. Writing 1 to status bit 1 while awake clears it.
- R11: rd_ready (also status bit 3) is 0 while asleep. It returns to 1 exactly REC_PERIOD*REC_PERIODS cycles after the wake edge.
- R12: After reset, the control register reads 0, status reads 5'b01000, susp_o and irq are 0 and clk_en is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_state | input | 2 | Decoded bus state (01 J, 10 K, 00 SE0, 11 SE1) |
| wake_req | input | 1 | Local application wake-up request |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 5 | Write data |
| reg_rdata | output | 5 | Read data of the selected register |
| irq | output | 1 | Interrupt request |
| clk_en | output | 1 | Internal clock enable, 0 during sleep |
| susp_o | output | 1 | Suspend pin, 1 during sleep |
| pwr_off | output | 1 | Sleep in bus-powered mode: cut external power |
| pad_hiz | output | 1 | Sleep in self-powered mode: tri-state shared pins |
| rd_ready | output | 1 | Register reads are valid |

## Verification
The hardest case to reach from the ports is the cancelled commit. The line must leave J in the narrow gap between the arming write and the committing write, and only after a full idle interval has set the flag. A directed sequence arms the commit, applies a single K sample, and then issues the write of 0 on a J line. The random phase uses long J runs close to IDLE_CYCLES, random lock settings and short K bursts, so that races between detection, arming and bus activity also occur at unplanned cycles. Every cycle is compared with a bench model built from the requirements.

// File: rtl/usb_susp_pkg.sv
package usb_susp_pkg;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_e;

    localparam int REG_W = 5;

    // control register bit positions
    localparam int C_LOCK  = 0;
    localparam int C_DIS   = 1;
    localparam int C_PWR   = 2;
    localparam int C_IESUS = 3;
    localparam int C_IERES = 4;

    // status register bit positions
    localparam int S_FLAG  = 0;
    localparam int S_RES   = 1;

    typedef struct packed {
        logic lock;
        logic det_dis;
        logic pwr_opt;
        logic ie_susp;
        logic ie_res;
        logic susp_flag;
        logic res_flag;
        logic armed;
        logic asleep;
    } ctl_t;

endpackage

// File: rtl/usb_susp_run_cnt.sv
module usb_susp_run_cnt #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic hit,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!en || !hit) begin
            cnt_d = '0;
        end else if (cnt_q != LAST) begin
            cnt_d = cnt_q + 1'b1;
        end
        done = en && hit && (cnt_q == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/usb_susp_rec_timer.sv
module usb_susp_rec_timer #(
    parameter int PERIOD  = 16,
    parameter int PERIODS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic idle
);
    localparam int WINDOW = PERIOD * PERIODS;
    localparam int CW     = $clog2(WINDOW + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = CW'(WINDOW);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
        idle = (cnt_q == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/usb_susp_ctl.sv
module usb_susp_ctl
    import usb_susp_pkg::*;
#(
    parameter int IDLE_CYCLES   = 36000,
    parameter int RESUME_CYCLES = 240,
    parameter int REC_PERIOD    = 16,
    parameter int REC_PERIODS   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       line_state,
    input  logic             wake_req,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq,
    output logic             clk_en,
    output logic             susp_o,
    output logic             pwr_off,
    output logic             pad_hiz,
    output logic             rd_ready
);
    ctl_t st_d, st_q;

    logic line_j, line_k;
    logic idle_en, idle_done, k_done, wake_hit, rec_idle;
    logic wr_ctl, wr_stat;

    // observation points for the bound checker
    logic susp_flag_w, res_flag_w, ie_susp_w;
    assign susp_flag_w = st_q.susp_flag;
    assign res_flag_w  = st_q.res_flag;
    assign ie_susp_w   = st_q.ie_susp;

    assign line_j   = (line_state == LS_J);
    assign line_k   = (line_state == LS_K);
    assign idle_en  = !st_q.det_dis && !st_q.asleep;
    assign wake_hit = st_q.asleep && (k_done || wake_req);
    assign wr_ctl   = reg_wr && !reg_sel;
    assign wr_stat  = reg_wr && reg_sel;

    usb_susp_run_cnt #(.LIMIT(IDLE_CYCLES)) u_idle (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (idle_en),
        .hit  (line_j),
        .done (idle_done)
    );

    usb_susp_run_cnt #(.LIMIT(RESUME_CYCLES)) u_kres (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (st_q.asleep),
        .hit  (line_k),
        .done (k_done)
    );

    usb_susp_rec_timer #(.PERIOD(REC_PERIOD), .PERIODS(REC_PERIODS)) u_rec (
        .clk  (clk),
        .rst_n(rst_n),
        .load (wake_hit),
        .idle (rec_idle)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.asleep) begin
            // bus activity cancels detection and any armed commit
            if (!line_j) begin
                st_d.susp_flag = 1'b0;
                st_d.armed     = 1'b0;
            end else if (idle_done) begin
                st_d.susp_flag = 1'b1;
            end
            if (wr_ctl) begin
                st_d.lock    = reg_wdata[C_LOCK];
                st_d.det_dis = reg_wdata[C_DIS];
                st_d.pwr_opt = reg_wdata[C_PWR];
                st_d.ie_susp = reg_wdata[C_IESUS];
                st_d.ie_res  = reg_wdata[C_IERES];
            end
            if (wr_stat) begin
                if (reg_wdata[S_RES]) begin
                    st_d.res_flag = 1'b0;
                end
                if (st_q.lock) begin
                    if (reg_wdata[S_FLAG]) begin
                        if (st_q.susp_flag && line_j) begin
                            st_d.armed = 1'b1;
                        end
                    end else if (st_q.armed && st_q.susp_flag && line_j) begin
                        st_d.asleep = 1'b1;
                        st_d.armed  = 1'b0;
                    end
                end
            end
        end else if (wake_hit) begin
            st_d.asleep    = 1'b0;
            st_d.susp_flag = 1'b0;
            st_d.res_flag  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_ready = rec_idle && !st_q.asleep;
        clk_en   = !st_q.asleep;
        susp_o   = st_q.asleep;
        pwr_off  = st_q.asleep && st_q.pwr_opt;
        pad_hiz  = st_q.asleep && !st_q.pwr_opt;
        irq      = (st_q.susp_flag && st_q.ie_susp) || (st_q.res_flag && st_q.ie_res);
        if (reg_sel) begin
            reg_rdata = {1'b0, rd_ready, st_q.asleep, st_q.res_flag, st_q.susp_flag};
        end else begin
            reg_rdata = {st_q.ie_res, st_q.ie_susp, st_q.pwr_opt, st_q.det_dis, st_q.lock};
        end
    end
endmodule

// File: rtl/usb_susp_ctl_chk.sv
module usb_susp_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic       reg_sel,
    input logic [4:0] reg_rdata,
    input logic       irq,
    input logic       susp_o,
    input logic       rd_ready,
    input logic       susp_flag_w,
    input logic       res_flag_w,
    input logic       ie_susp_w
);
    AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_o && reg_wr && !reg_sel) |=> (reg_sel || reg_rdata == $past(reg_rdata))); // R5

    AST_SLEEP_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(susp_o) |-> $past(susp_flag_w)); // R3

    AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        susp_o |-> susp_flag_w); // R6

    AST_IRQ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_o && ie_susp_w) |-> irq); // R6

    AST_WAKE_NOTIFY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(susp_o) |-> (res_flag_w && !susp_flag_w)); // R10

    AST_NO_READ_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        susp_o |-> !rd_ready); // R11

    AST_RDY_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(susp_o) |-> !rd_ready); // R11
endmodule

bind usb_susp_ctl usb_susp_ctl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .reg_rdata  (reg_rdata),
    .irq        (irq),
    .susp_o     (susp_o),
    .rd_ready   (rd_ready),
    .susp_flag_w(susp_flag_w),
    .res_flag_w (res_flag_w),
    .ie_susp_w  (ie_susp_w)
);

// File: tb/usb_susp_ctl_tb.sv
`timescale 1ns/1ps
module usb_susp_ctl_tb;
    localparam int IDLE = 40;
    localparam int RES  = 6;
    localparam int PER  = 3;
    localparam int PERS = 3;
    localparam int WIN  = PER * PERS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] line = 2'b00;
    logic       wake = 1'b0;
    logic       wr = 1'b0;
    logic       sel = 1'b0;
    logic [4:0] wdata = '0;
    logic [4:0] rdata;
    logic       irq, clk_en, susp_o, pwr_off, pad_hiz, rd_ready;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    usb_susp_ctl #(
        .IDLE_CYCLES(IDLE), .RESUME_CYCLES(RES), .REC_PERIOD(PER), .REC_PERIODS(PERS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .line_state(line), .wake_req(wake),
        .reg_wr(wr), .reg_sel(sel), .reg_wdata(wdata), .reg_rdata(rdata),
        .irq(irq), .clk_en(clk_en), .susp_o(susp_o), .pwr_off(pwr_off),
        .pad_hiz(pad_hiz), .rd_ready(rd_ready)
    );

    // reference model state, built from the requirements
    logic m_lock, m_dis, m_pwr, m_ies, m_ier, m_flag, m_res, m_arm, m_sleep;
    int   m_jrun, m_krun, m_rec;

    function automatic logic [4:0] exp_ctl();
        return {m_ier, m_ies, m_pwr, m_dis, m_lock};
    endfunction

    function automatic logic [4:0] exp_stat();
        return {1'b0, exp_ready(), m_sleep, m_res, m_flag};
    endfunction

    function automatic logic exp_ready();
        return !m_sleep && (m_rec == 0);
    endfunction

    function automatic logic exp_irq();
        return (m_flag && m_ies) || (m_res && m_ier);
    endfunction

    task automatic model_reset();
        {m_lock, m_dis, m_pwr, m_ies, m_ier, m_flag, m_res, m_arm, m_sleep} = '0;
        m_jrun = 0; m_krun = 0; m_rec = 0;
    endtask

    task automatic model_step();
        logic o_lock, o_flag, o_arm, isj;
        if (!rst_n) begin
            model_reset();
            return;
        end
        o_lock = m_lock; o_flag = m_flag; o_arm = m_arm;
        isj = (line == 2'b01);
        if (m_rec > 0) m_rec--;
        if (!m_sleep) begin
            m_krun = 0;
            if (m_dis || !isj) m_jrun = 0;
            else m_jrun++;
            if (!isj) begin
                m_flag = 1'b0; m_arm = 1'b0;
            end else if (m_jrun >= IDLE) begin
                m_flag = 1'b1;
            end
            if (wr && !sel) {m_ier, m_ies, m_pwr, m_dis, m_lock} = wdata;
            if (wr && sel) begin
                if (wdata[1]) m_res = 1'b0;
                if (o_lock) begin
                    if (wdata[0]) begin
                        if (o_flag && isj) m_arm = 1'b1;
                    end else if (o_arm && o_flag && isj) begin
                        m_sleep = 1'b1; m_arm = 1'b0;
                    end
                end
            end
        end else begin
            m_jrun = 0;
            if (line == 2'b10) m_krun++;
            else m_krun = 0;
            if (m_krun >= RES || wake) begin
                m_sleep = 1'b0; m_flag = 1'b0; m_res = 1'b1;
                m_rec = WIN; m_krun = 0;
            end
        end
    endtask

    task automatic chk(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic compare_all();
        if (!rst_n) return;
        chk("R3 susp_o", susp_o, m_sleep);
        chk("R3 clk_en", clk_en, !m_sleep);
        chk("R8 pwr_off", pwr_off, m_sleep && m_pwr);
        chk("R8 pad_hiz", pad_hiz, m_sleep && !m_pwr);
        chk("R6 irq", irq, exp_irq());
        chk("R11 rd_ready", rd_ready, exp_ready());
        chk("R1 reg_rdata", rdata, sel ? exp_stat() : exp_ctl());
    endtask

    task automatic tick();
        @(posedge clk);
        cyc++;
        model_step();
        #1;
        compare_all();
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic reg_write(logic s, logic [4:0] d);
        wr = 1'b1; sel = s; wdata = d;
        tick();
        wr = 1'b0;
    endtask

    task automatic read_chk(string tag, logic s, int exp);
        sel = s;
        #0.5;
        chk(tag, rdata, exp);
    endtask

    initial begin : watchdog
        #(150000 * 5);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin : stim
        int seg;
        logic [1:0] seg_line;
        void'($urandom(32'd20240611));
        model_reset();
        ticks(3);
        rst_n = 1'b1;
        #0.5;
        // R12 reset state
        read_chk("R12 ctrl after reset", 1'b0, 0);
        read_chk("R12 status after reset", 1'b1, 5'b01000);
        chk("R12 susp_o", susp_o, 0);
        chk("R12 clk_en", clk_en, 1);
        chk("R12 irq", irq, 0);

        // R1 detection boundary
        reg_write(1'b0, 5'b11000);
        line = 2'b01;
        ticks(IDLE - 1);
        read_chk("R1 flag one short", 1'b1, 5'b01000);
        tick();
        read_chk("R1 flag at limit", 1'b1, 5'b01001);
        chk("R6 irq on detect", irq, 1);

        // R4 commit without lock
        reg_write(1'b1, 5'b00001);
        reg_write(1'b1, 5'b00000);
        chk("R4 no sleep without lock", susp_o, 0);

        // R7 bus activity between the two writes
        reg_write(1'b0, 5'b11001);
        reg_write(1'b1, 5'b00001);
        line = 2'b10;
        tick();
        read_chk("R7 flag cleared by K", 1'b1, 5'b01000);
        line = 2'b01;
        reg_write(1'b1, 5'b00000);
        chk("R7 cancelled commit", susp_o, 0);

        // R3 proper commit, self-powered
        ticks(IDLE);
        read_chk("R1 flag again", 1'b1, 5'b01001);
        reg_write(1'b1, 5'b00001);
        reg_write(1'b1, 5'b00000);
        chk("R3 susp_o", susp_o, 1);
        chk("R3 clk_en", clk_en, 0);
        chk("R8 pad_hiz self-powered", pad_hiz, 1);
        chk("R8 pwr_off self-powered", pwr_off, 0);
        chk("R11 not ready asleep", rd_ready, 0);

        // R5 writes refused while asleep
        reg_write(1'b0, 5'b00000);
        read_chk("R5 ctrl unchanged", 1'b0, 5'b11001);
        reg_write(1'b1, 5'b00010);

        // R6 flag held during sleep
        line = 2'b00;
        ticks(5);
        read_chk("R6 flag held asleep", 1'b1, 5'b00101);
        chk("R6 irq pending asleep", irq, 1);

        // R9 short K then full K
        line = 2'b10;
        ticks(RES - 1);
        line = 2'b01;
        tick();
        chk("R9 short K no wake", susp_o, 1);
        line = 2'b10;
        ticks(RES);
        chk("R9 wake on K", susp_o, 0);
        chk("R9 clk_en back", clk_en, 1);
        read_chk("R10 resume flag set", 1'b1, 5'b00010);
        line = 2'b01;
        ticks(WIN - 1);
        chk("R11 window not over", rd_ready, 0);
        tick();
        chk("R11 window over", rd_ready, 1);

        // R10 clear resume flag
        reg_write(1'b1, 5'b00010);
        read_chk("R10 resume flag cleared", 1'b1, 5'b01000);

        // R8 bus-powered sleep, R10 local wake
        reg_write(1'b0, 5'b11101);
        ticks(IDLE);
        reg_write(1'b1, 5'b00001);
        reg_write(1'b1, 5'b00000);
        chk("R8 pwr_off bus-powered", pwr_off, 1);
        chk("R8 pad_hiz bus-powered", pad_hiz, 0);
        wake = 1'b1;
        tick();
        wake = 1'b0;
        chk("R10 wake_req wakes", susp_o, 0);
        read_chk("R10 resume after wake_req", 1'b1, 5'b00010);

        // R2 detection disabled
        reg_write(1'b0, 5'b00010);
        line = 2'b00;
        tick();
        line = 2'b01;
        ticks(2 * IDLE);
        read_chk("R2 no detect when disabled", 1'b1, 5'b01010);

        // random phase
        reg_write(1'b0, 5'b00000);
        seg = 0;
        seg_line = 2'b01;
        for (int i = 0; i < 5000; i++) begin
            if (seg == 0) begin
                int r;
                r = $urandom % 20;
                if (r < 12) begin
                    seg_line = 2'b01; seg = 1 + ($urandom % (IDLE + 20));
                end else if (r < 17) begin
                    seg_line = 2'b10; seg = 1 + ($urandom % (2 * RES));
                end else begin
                    seg_line = ($urandom % 2) ? 2'b00 : 2'b11; seg = 1 + ($urandom % 4);
                end
            end
            seg--;
            line = seg_line;
            wake = (($urandom % 64) == 0);
            wr = (($urandom % 6) == 0);
            sel = $urandom % 2;
            wdata = 5'($urandom) & 5'b11101;
            if (($urandom % 200) == 0) wdata[1] = 1'b1;
            tick();
        end
        wr = 1'b0;
        wake = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule